// File: doc/BRIEF.md
# Bounded Synaptic Weight Update Engine

This block holds one bounded weight per input of a single output neuron and updates all of them together whenever the neuron fires. Each input presents one spike bit. A firing neuron raises a one-cycle strobe. On that strobe, every input that is spiking gains a fixed potentiation step. Every input that is silent loses a depression step, but only if the strobe's pulse-type flag allows depression. With no strobe, all weights hold, whatever the spike bits are doing.

The depression step is a run-time integer multiple `m` of the potentiation step. Setting `m = 1` models a symmetric device, and larger values model a device whose depression is much stronger than its potentiation. Weights are unsigned fixed point. Full scale is 50 potentiation steps, so one step is 1/50 of the normalised range. Weights clamp at zero and at full scale.

A write port loads initial weights and a read port returns any weight. Two running counters record how many individual synapse potentiation and depression operations were issued. This lets a surrounding bench compare how many depression operations different pulse schemes need.

Top module: `syn_update_engine`

## Requirements
- R1: While `post_stb` is 0, no weight changes, whatever `pre_spk` carries.
- R2: On a cycle with `post_stb` = 1, every weight whose `pre_spk` bit is 1 becomes min(w + 1, 50) at the next clock edge. One unit is 1/50 of full scale.
- R3: On a cycle with `post_stb` = 1 and `ltp_only` = 0, every weight whose `pre_spk` bit is 0 becomes max(w − m, 0), where m is the value on `ltd_mult`.
- R4: The depression multiple is taken from `ltd_mult` on the strobe cycle itself. Different strobes may therefore use m = 1, 4 or 20.
- R5: On a strobe with `ltp_only` = 1, weights whose `pre_spk` bit is 0 keep their value, while spiking inputs are still potentiated.
- R6: Weights stay within 0 to 50. Repeated potentiation stops at 50 and repeated depression stops at 0, with no wrap.
- R7: With `wr_en` = 1, the weight at `wr_addr` becomes min(`wr_data`, 50) at the next edge. This write overrides any strobe update of that same weight in that cycle. Other weights still update. An address of 784 or above changes nothing.
- R8: `rd_data` shows, without a clock, the weight at `rd_addr`. It reads 0 for an address of 784 or above.
- R9: On each strobe, `ltp_ops` adds the number of 1 bits in `pre_spk`. When `ltp_only` is 0, `ltd_ops` adds the number of 0 bits. Both counters hold when there is no strobe, and they count issued operations even when a weight is already at a limit.
- R10: After reset, all weights and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_spk | input | 784 | Pre-synaptic spike bit per input |
| post_stb | input | 1 | Post-synaptic firing strobe |
| ltp_only | input | 1 | 1: this strobe potentiates only, with no depression |
| ltd_mult | input | 5 | Depression multiple m, in potentiation steps |
| wr_en | input | 1 | Weight write enable |
| wr_addr | input | 10 | Weight write address |
| wr_data | input | 6 | Weight write value, clamped to 50 |
| rd_addr | input | 10 | Weight read address |
| rd_data | output | 6 | Weight at `rd_addr` |
| ltp_ops | output | 32 | Total synapse potentiation operations issued |
| ltd_ops | output | 32 | Total synapse depression operations issued |

## Verification
The bench drives weights into both limits. A design that wraps instead of clamping would turn a 50 into a small value, or a small value into a large one, after the long potentiation run or the m = 20 depression run. It issues a strobe with `ltp_only` set against a mostly silent pattern; a design that ignores the flag would lower those silent weights and also advance `ltd_ops`. It collides a write with a strobe on the same address, writes an over-range value and an out-of-range address, and reads out of range. A wrong priority, a missing clamp, an address alias or a garbage read would each show up in the full weight readout that follows.

// File: rtl/syn_pkg.sv
package syn_pkg;
   // operation chosen for one weight in a cycle
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_POT  = 2'd1,
      OP_DEP  = 2'd2,
      OP_LOAD = 2'd3
   } syn_op_e;

   // minimum bits to hold the value v
   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned b;
      b = 1;
      while ((1 << b) <= v) b++;
      return b;
   endfunction
endpackage

// File: rtl/syn_popcount.sv
module syn_popcount #(
   parameter int unsigned WIDTH = 784,
   parameter int unsigned CW    = 10
) (
   input  logic [WIDTH-1:0] bits_in,
   output logic [CW-1:0]    ones
);
   if ((1 << CW) <= WIDTH) begin : g_bad_cw
      $error("syn_popcount: CW too narrow for WIDTH");
   end

   always_comb begin
      ones = '0;
      for (int i = 0; i < WIDTH; i++) begin
         ones = ones + CW'(bits_in[i]);
      end
   end
endmodule

// File: rtl/syn_cell.sv
module syn_cell
   import syn_pkg::*;
#(
   parameter int unsigned FULL_SCALE = 50,
   parameter int unsigned POT_STEP   = 1,
   parameter int unsigned W_BITS     = 6,
   parameter int unsigned SW         = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pre,
   input  logic              post,
   input  logic              dep_en,
   input  logic [SW-1:0]     dep_step,
   input  logic              wr_hit,
   input  logic [W_BITS-1:0] wr_val,
   output logic [W_BITS-1:0] w_out
);
   localparam int unsigned EW = ((SW > W_BITS) ? SW : W_BITS) + 1;

   logic [W_BITS-1:0] w_q, w_d;
   logic [EW-1:0]     w_ext, up_sum, step_ext;
   syn_op_e           op;

   always_comb begin
      if (wr_hit)                  op = OP_LOAD;
      else if (post && pre)        op = OP_POT;
      else if (post && dep_en)     op = OP_DEP;
      else                         op = OP_HOLD;
   end

   always_comb begin
      w_ext    = EW'(w_q);
      step_ext = EW'(dep_step);
      up_sum   = w_ext + EW'(POT_STEP);
      unique case (op)
         OP_LOAD: w_d = wr_val;
         OP_POT:  w_d = (up_sum > EW'(FULL_SCALE)) ? W_BITS'(FULL_SCALE)
                                                   : W_BITS'(up_sum);
         OP_DEP:  w_d = (w_ext < step_ext) ? '0 : W_BITS'(w_ext - step_ext);
         default: w_d = w_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) w_q <= '0;
      else        w_q <= w_d;
   end

   assign w_out = w_q;

   a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      w_q <= W_BITS'(FULL_SCALE));
   a_r1_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!post && !wr_hit) |=> $stable(w_q));
   a_r2_pot_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (post && pre && !wr_hit) |=> ((w_q > $past(w_q)) || (w_q == W_BITS'(FULL_SCALE))));
   a_r3_dep_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (post && !pre && dep_en && !wr_hit) |=> (w_q <= $past(w_q)));
   a_r5_pot_only_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (post && !pre && !dep_en && !wr_hit) |=> $stable(w_q));
   a_r7_load_clamped: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (w_q == $past(wr_val)));
endmodule

// File: rtl/syn_update_engine.sv
module syn_update_engine
   import syn_pkg::*;
#(
   parameter int unsigned N_IN       = 784,
   parameter int unsigned FULL_SCALE = 50,
   parameter int unsigned POT_STEP   = 1,
   parameter int unsigned M_BITS     = 5,
   parameter int unsigned CNT_BITS   = 32,
   parameter int unsigned W_BITS     = bits_for(FULL_SCALE),
   parameter int unsigned A_BITS     = bits_for(N_IN - 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_IN-1:0]     pre_spk,
   input  logic                post_stb,
   input  logic                ltp_only,
   input  logic [M_BITS-1:0]   ltd_mult,
   input  logic                wr_en,
   input  logic [A_BITS-1:0]   wr_addr,
   input  logic [W_BITS-1:0]   wr_data,
   input  logic [A_BITS-1:0]   rd_addr,
   output logic [W_BITS-1:0]   rd_data,
   output logic [CNT_BITS-1:0] ltp_ops,
   output logic [CNT_BITS-1:0] ltd_ops
);
   localparam int unsigned SW = M_BITS + W_BITS;
   localparam int unsigned PW = bits_for(N_IN);

   if (N_IN < 1) begin : g_bad_n
      $error("syn_update_engine: N_IN must be at least 1");
   end
   if (POT_STEP < 1 || POT_STEP > FULL_SCALE) begin : g_bad_step
      $error("syn_update_engine: POT_STEP must lie in 1..FULL_SCALE");
   end
   if ((1 << W_BITS) <= FULL_SCALE) begin : g_bad_w
      $error("syn_update_engine: W_BITS too narrow for FULL_SCALE");
   end
   if (CNT_BITS < PW) begin : g_bad_cnt
      $error("syn_update_engine: CNT_BITS narrower than one event");
   end

   logic [SW-1:0]     dep_step;
   logic [W_BITS-1:0] wr_val;
   logic [W_BITS-1:0] w_all [N_IN];
   logic [PW-1:0]     pot_n, dep_n;
   logic              dep_en;

   // depression step = m * potentiation step
   if (POT_STEP == 1) begin : g_unit_step
      assign dep_step = SW'(ltd_mult);
   end else begin : g_scaled_step
      assign dep_step = SW'(ltd_mult) * SW'(POT_STEP);
   end

   assign wr_val = (wr_data > W_BITS'(FULL_SCALE)) ? W_BITS'(FULL_SCALE) : wr_data;
   assign dep_en = !ltp_only;

   for (genvar i = 0; i < N_IN; i++) begin : g_cell
      syn_cell #(
         .FULL_SCALE(FULL_SCALE),
         .POT_STEP  (POT_STEP),
         .W_BITS    (W_BITS),
         .SW        (SW)
      ) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .pre     (pre_spk[i]),
         .post    (post_stb),
         .dep_en  (dep_en),
         .dep_step(dep_step),
         .wr_hit  (wr_en && (wr_addr == A_BITS'(i))),
         .wr_val  (wr_val),
         .w_out   (w_all[i])
      );
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_IN; i++) begin
         if (rd_addr == A_BITS'(i)) rd_data = w_all[i];
      end
   end

   syn_popcount #(.WIDTH(N_IN), .CW(PW)) u_pop (
      .bits_in(pre_spk),
      .ones   (pot_n)
   );
   assign dep_n = PW'(N_IN) - pot_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ltp_ops <= '0;
         ltd_ops <= '0;
      end else if (post_stb) begin
         ltp_ops <= ltp_ops + CNT_BITS'(pot_n);
         if (dep_en) ltd_ops <= ltd_ops + CNT_BITS'(dep_n);
      end
   end

   a_r9_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !post_stb |=> ($stable(ltp_ops) && $stable(ltd_ops)));
   a_r5_no_dep_count: assert property (@(posedge clk) disable iff (!rst_n)
      (post_stb && ltp_only) |=> $stable(ltd_ops));
   a_r8_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data <= W_BITS'(FULL_SCALE));
endmodule

// File: tb/syn_update_engine_test.sv
module syn_update_engine_test;
   localparam int N  = 784;
   localparam int WB = 6;
   localparam int MB = 5;
   localparam int AB = 10;
   localparam int CB = 32;
   localparam int FS = 50;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pre_spk = '0;
   logic          post_stb = 1'b0, ltp_only = 1'b0, wr_en = 1'b0;
   logic [MB-1:0] ltd_mult = '0;
   logic [AB-1:0] wr_addr = '0, rd_addr = '0;
   logic [WB-1:0] wr_data = '0;
   logic [WB-1:0] rd_data;
   logic [CB-1:0] ltp_ops, ltd_ops;

   always #2 clk = ~clk;

   syn_update_engine uut (
      .clk(clk), .rst_n(rst_n), .pre_spk(pre_spk), .post_stb(post_stb),
      .ltp_only(ltp_only), .ltd_mult(ltd_mult), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .ltp_ops(ltp_ops), .ltd_ops(ltd_ops)
   );

   typedef struct {
      bit      is_cnt;
      int      addr;
      int      exp;
      longint  e_pot;
      longint  e_dep;
      string   tag;
   } item_t;

   item_t  sb[$];
   item_t  cur;
   int     n_chk = 0, n_fail = 0;
   int     model [N];
   longint m_pot = 0, m_dep = 0;
   bit     finished = 1'b0;

   // monitor: one expected item per cycle, sampled at the falling edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         cur = sb.pop_front();
         n_chk++;
         if (cur.is_cnt) begin
            if (longint'(ltp_ops) != cur.e_pot || longint'(ltd_ops) != cur.e_dep) begin
               n_fail++;
               $display("FAIL %s counters: ltp_ops=%0d ltd_ops=%0d expected %0d %0d",
                        cur.tag, ltp_ops, ltd_ops, cur.e_pot, cur.e_dep);
            end
         end else if (int'(rd_data) != cur.exp) begin
            n_fail++;
            $display("FAIL %s weight[%0d]: got %0d expected %0d",
                     cur.tag, cur.addr, rd_data, cur.exp);
         end
      end
   end

   task automatic rd_chk(input int a, input int e, input string tag);
      item_t it;
      @(posedge clk); #1;
      rd_addr = AB'(a);
      it.is_cnt = 1'b0; it.addr = a; it.exp = e; it.e_pot = 0; it.e_dep = 0; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic chk_all(input string tag);
      item_t it;
      for (int a = 0; a < N; a++) rd_chk(a, model[a], tag);
      @(posedge clk); #1;
      it.is_cnt = 1'b1; it.addr = 0; it.exp = 0; it.e_pot = m_pot; it.e_dep = m_dep;
      it.tag = {tag, " R9"};
      sb.push_back(it);
      @(posedge clk); #1;
   endtask

   task automatic wr(input int a, input int d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = AB'(a); wr_data = WB'(d);
      if (a < N) model[a] = (d > FS) ? FS : d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [N-1:0] p, input bit lo, input int m,
                        input bit w = 1'b0, input int wa = 0, input int wd = 0);
      @(posedge clk); #1;
      pre_spk = p; post_stb = 1'b1; ltp_only = lo; ltd_mult = MB'(m);
      wr_en = w; wr_addr = AB'(wa); wr_data = WB'(wd);
      for (int i = 0; i < N; i++) begin
         if (p[i]) begin
            model[i] = (model[i] + 1 > FS) ? FS : model[i] + 1;
            m_pot++;
         end else if (!lo) begin
            model[i] = (model[i] - m < 0) ? 0 : model[i] - m;
            m_dep++;
         end
      end
      if (w && wa < N) model[wa] = (wd > FS) ? FS : wd;
      @(posedge clk); #1;
      post_stb = 1'b0; wr_en = 1'b0; pre_spk = '0; ltp_only = 1'b0;
   endtask

   initial begin
      logic [N-1:0] pa, pb;
      for (int i = 0; i < N; i++) model[i] = 0;
      for (int i = 0; i < N; i++) begin
         pa[i] = (i % 3 == 0);
         pb[i] = (i % 2 == 1);
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk_all("R10");

      for (int i = 0; i < N; i++) wr(i, i % 51);
      wr(5, 60);                          // R7 clamp
      wr(800, 9);                         // R7 out-of-range address ignored
      chk_all("R7");

      // R1: spikes without a strobe
      @(posedge clk); #1;
      pre_spk = '1;
      repeat (5) @(posedge clk);
      #1 pre_spk = '0;
      chk_all("R1");

      pulse(pa, 1'b0, 1);
      chk_all("R2/R3");
      pulse(pb, 1'b0, 4);
      chk_all("R4");
      pulse(pa, 1'b1, 20);
      chk_all("R5");
      repeat (3) pulse('0, 1'b0, 20);
      chk_all("R6 floor");
      repeat (55) pulse('1, 1'b0, 7);
      chk_all("R6 ceiling");
      pulse(pb, 1'b0, 3, 1'b1, 7, 33);    // write collides with strobe on addr 7
      chk_all("R7 collide");
      rd_chk(900, 0, "R8");
      rd_chk(N, 0, "R8");
      @(posedge clk); #1;
      @(posedge clk); #1;

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, got timeout expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule